// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register

This block holds the control and status registers of one bus-master DMA channel in an audio/modem link controller. Software reaches it through a simple request port that takes byte, word and dword accesses. The 8-bit control byte holds three interrupt enables, a run/pause level and a reset command that clears itself. The reset command returns the channel's registers to their defaults but keeps the enables.

The DMA engine reports three kinds of event: a buffer completed, the last valid buffer was reached, and a FIFO error occurred. Each event sets a sticky status flag whether or not its interrupt is enabled. Software clears a flag by writing 1 to it. A completion counter counts every finished buffer.

One registered interrupt line combines each flag with its enable. The engine receives a level run signal and a one-cycle reset pulse. Pausing only freezes the engine, so the counter and the flags keep their values.

Top module: `dmac_chan`

## Requirements
- R1: After a synchronous active-low reset, the control byte, status flags and completion counter are 0, and `irq`, `dma_run`, `dma_rst`, `proto_err` and `acc_err` are low.
- R2: The control byte lives in lane 3 of the dword at offset 08h. Its fields are: bit 0 = run, bit 1 = reset command, bit 2 = last-valid interrupt enable, bit 3 = FIFO-error interrupt enable, bit 4 = completion interrupt enable. Bits 7:5 and bit 1 always read as 0. `dma_run` follows bit 0 from the cycle after the write.
- R3: A control write with bit 1 = 1 while run is 0 does the following at the write edge: it clears the status flags, the counter and run, and it loads the enables from the written bits 4:2. It also raises `dma_rst` for exactly one cycle, together with the cleared state.
- R4: A control write with bit 1 = 1 while run is 1 leaves the flags, the counter and `dma_rst` unchanged and raises `proto_err` for one cycle. The write's other bits still take effect.
- R5: `ev_buf_done` increments the 8-bit completion counter (lane 2, wrapping modulo 256). It sets status bit 3 only when `ev_ioc` is also high.
- R6: `ev_fifo_err` sets status bit 4 and `ev_last_valid` sets status bit 2, whatever the enables hold. A disabled flag never raises `irq`.
- R7: Writing 1 to a status bit in lane 0 clears it. An event in the same cycle wins over the clear.
- R8: `irq` is high exactly when, one cycle earlier, some status bit 2, 3 or 4 was set together with its enable (control bit 2, 4 or 3 respectively).
- R9: Read data is right-justified. The dword at 08h reads as {control, counter, 8'h00, status}. Byte and word reads return the addressed lanes. Any other dword address reads 0 without error.
- R10: An access with size code 3, or one that spans past byte 3 of its dword, returns 0 and raises `acc_err` for one cycle. As a write, it changes nothing. Size codes: 0 = byte, 1 = word, 2 = dword.
- R11: `rd_valid` and the read data appear in the cycle after a read request and show the register state from before that request's edge.
- R12: Clearing run changes neither the counter nor the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 unsupported |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Right-justified write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Right-justified read data |
| acc_err | output | 1 | Unsupported or boundary-crossing access |
| proto_err | output | 1 | Reset command refused while running |
| ev_buf_done | input | 1 | Engine finished a buffer |
| ev_ioc | input | 1 | Finished buffer asked for a completion interrupt |
| ev_last_valid | input | 1 | Engine reached the last valid buffer |
| ev_fifo_err | input | 1 | Engine FIFO overrun or underrun |
| irq | output | 1 | Channel interrupt |
| dma_run | output | 1 | Run level to the engine |
| dma_rst | output | 1 | One-cycle engine reset pulse |

## Verification
Each result has a fixed latency. A status flag is visible to a read issued in the cycle after its event, and `irq` follows one cycle later still. Read data, `acc_err`, `proto_err` and `dma_rst` come one cycle after the request, and `dma_run` changes in the cycle after the control write. The bench drives inputs on the falling edge and steps a behavioural model on each rising edge. It compares every output against the model at the next falling edge, so each expected value lands on exactly the cycle given above. Directed reads placed right after each event, write and error case confirm the flags, the counter and the control byte by hand-computed values.

// File: rtl/dmac_pkg.sv
// Package: shared encodings for the DMA channel register block.
// Assumes: a single 32-bit register dword, little-endian lane numbering.
package dmac_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE  = 2'd0,
        ACC_WORD  = 2'd1,
        ACC_DWORD = 2'd2,
        ACC_BAD   = 2'd3
    } acc_size_e;

    // Control byte fields
    localparam int CTL_RUN     = 0;
    localparam int CTL_RSTCMD  = 1;
    localparam int CTL_LVB_EN  = 2;
    localparam int CTL_FERR_EN = 3;
    localparam int CTL_DONE_EN = 4;

    // Status byte fields
    localparam int STS_LVB  = 2;
    localparam int STS_DONE = 3;
    localparam int STS_FERR = 4;
    localparam logic [7:0] STS_IMPL = 8'h1C;

    // Byte lanes inside the register dword
    localparam int LANE_STS = 0;
    localparam int LANE_IDX = 2;
    localparam int LANE_CTL = 3;

    // Number of bytes an access size covers; 0 marks an unsupported size
    function automatic logic [2:0] acc_bytes(input acc_size_e s);
        case (s)
            ACC_BYTE:  return 3'd1;
            ACC_WORD:  return 3'd2;
            ACC_DWORD: return 3'd4;
            default:   return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dmac_bus_dec.sv
// Module: access decoder. Turns size and address into byte lanes, aligns
// write data to its lanes and builds the read mask; flags accesses with an
// unsupported size or that run past the end of their dword.
// Assumes: a purely combinational path; the caller registers the results.
module dmac_bus_dec
    import dmac_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_BASE = 8'h08
) (
    input  logic              req_valid,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              hit,
    output logic              bad,
    output logic [3:0]        lanes,
    output logic [31:0]       wr_word,
    output logic [1:0]        lane_sel,
    output logic [31:0]       rd_mask
);

    localparam int DW_BITS = ADDR_W - 2;
    localparam logic [DW_BITS-1:0] BASE_DW = REG_BASE[ADDR_W-1:2];

    logic [2:0] nbytes;
    logic [2:0] last;
    logic [3:0] span;

    // Purpose: work out size, span and error of the request
    always_comb begin
        nbytes   = acc_bytes(acc_size_e'(req_size));
        lane_sel = req_addr[1:0];
        last     = {1'b0, lane_sel} + nbytes;
        bad      = req_valid && ((nbytes == 3'd0) || (last > 3'd4));
        hit      = req_valid && (req_addr[ADDR_W-1:2] == BASE_DW);
        case (nbytes)
            3'd1:    span = 4'b0001;
            3'd2:    span = 4'b0011;
            3'd4:    span = 4'b1111;
            default: span = 4'b0000;
        endcase
        lanes   = bad ? 4'b0000 : (span << lane_sel);
        wr_word = req_wdata << {lane_sel, 3'b000};
    end

    // Purpose: expand the right-justified span into a bit mask for reads
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            rd_mask[8*i +: 8] = {8{span[i]}};
        end
    end

endmodule

// File: rtl/dmac_ctl_reg.sv
// Module: control byte. Holds run and the three enables, and decodes the
// self-clearing reset command against the current run state.
// Assumes: wr_en is a qualified write to the control lane.
module dmac_ctl_reg
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output logic       run,
    output logic       en_done,
    output logic       en_ferr,
    output logic       en_lvb,
    output logic       soft_rst,
    output logic       proto_hit,
    output logic [7:0] ctl_byte
);

    logic cmd;

    // Purpose: decode the reset command against the run state before the write
    always_comb begin
        cmd       = wr_en && wr_byte[CTL_RSTCMD];
        soft_rst  = cmd && !run;
        proto_hit = cmd && run;
    end

    // Purpose: store enables and run; an accepted reset command forces run low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            en_done <= 1'b0;
            en_ferr <= 1'b0;
            en_lvb  <= 1'b0;
        end else if (wr_en) begin
            en_done <= wr_byte[CTL_DONE_EN];
            en_ferr <= wr_byte[CTL_FERR_EN];
            en_lvb  <= wr_byte[CTL_LVB_EN];
            run     <= soft_rst ? 1'b0 : wr_byte[CTL_RUN];
        end
    end

    // Purpose: readback image; the command bit and reserved bits read zero
    always_comb begin
        ctl_byte              = 8'h00;
        ctl_byte[CTL_RUN]     = run;
        ctl_byte[CTL_LVB_EN]  = en_lvb;
        ctl_byte[CTL_FERR_EN] = en_ferr;
        ctl_byte[CTL_DONE_EN] = en_done;
    end

endmodule

// File: rtl/dmac_stat_reg.sv
// Module: sticky status flags and the completion counter. Events set flags,
// a write-1 mask clears them (set wins), the reset command clears everything.
// Assumes: IDX_W is at most 8 so the counter fits its byte lane.
module dmac_stat_reg
    import dmac_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [7:0]       clr_mask,
    input  logic             ev_buf_done,
    input  logic             ev_ioc,
    input  logic             ev_last_valid,
    input  logic             ev_fifo_err,
    output logic [7:0]       sts_byte,
    output logic [IDX_W-1:0] idx
);

    logic [7:0] set_vec;

    // Purpose: map engine events onto status bit positions
    always_comb begin
        set_vec           = 8'h00;
        set_vec[STS_LVB]  = ev_last_valid;
        set_vec[STS_DONE] = ev_buf_done && ev_ioc;
        set_vec[STS_FERR] = ev_fifo_err;
    end

    for (genvar i = 0; i < 8; i++) begin : g_flag
        if (STS_IMPL[i]) begin : g_impl
            // Purpose: one sticky flag with write-1-to-clear
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) begin
                    sts_byte[i] <= 1'b0;
                end else if (set_vec[i]) begin
                    sts_byte[i] <= 1'b1;
                end else if (clr_mask[i]) begin
                    sts_byte[i] <= 1'b0;
                end
            end
        end else begin : g_rsvd
            assign sts_byte[i] = 1'b0;
        end
    end

    // Purpose: count finished buffers, wrapping at the counter width
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            idx <= '0;
        end else if (ev_buf_done) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/dmac_irq.sv
// Module: interrupt combiner. Registers the OR of each flag with its enable.
// Assumes: en_mask uses the same bit positions as the status byte.
module dmac_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sts_byte,
    input  logic [7:0] en_mask,
    output logic       irq
);

    // Purpose: one-cycle registered interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |(sts_byte & en_mask);
        end
    end

endmodule

// File: rtl/dmac_chan.sv
// Module: top of one DMA channel's control/status register block. Decodes
// accesses, writes the control and status registers, returns registered
// read data and drives the interrupt and the engine's run/reset lines.
// Assumes: one access per cycle; reads and writes never share a cycle.
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_BASE = 8'h08,
    parameter int               IDX_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              acc_err,
    output logic              proto_err,
    input  logic              ev_buf_done,
    input  logic              ev_ioc,
    input  logic              ev_last_valid,
    input  logic              ev_fifo_err,
    output logic              irq,
    output logic              dma_run,
    output logic              dma_rst
);

    logic             hit, bad;
    logic [3:0]       lanes;
    logic [31:0]      wr_word, rd_mask, reg_dw;
    logic [1:0]       lane_sel;
    logic             wr_ok, ctl_wr;
    logic [7:0]       clr_mask, ctl_byte, sts_byte, idx_byte, en_mask;
    logic             run, en_done, en_ferr, en_lvb, soft_rst, proto_hit;
    logic [IDX_W-1:0] idx;

    dmac_bus_dec #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_dec (
        .req_valid (req_valid),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .hit       (hit),
        .bad       (bad),
        .lanes     (lanes),
        .wr_word   (wr_word),
        .lane_sel  (lane_sel),
        .rd_mask   (rd_mask)
    );

    // Purpose: qualify writes and route lanes to the registers
    always_comb begin
        wr_ok    = req_valid && req_write && hit && !bad;
        ctl_wr   = wr_ok && lanes[LANE_CTL];
        clr_mask = (wr_ok && lanes[LANE_STS]) ? wr_word[8*LANE_STS +: 8] : 8'h00;
    end

    dmac_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr),
        .wr_byte   (wr_word[8*LANE_CTL +: 8]),
        .run       (run),
        .en_done   (en_done),
        .en_ferr   (en_ferr),
        .en_lvb    (en_lvb),
        .soft_rst  (soft_rst),
        .proto_hit (proto_hit),
        .ctl_byte  (ctl_byte)
    );

    dmac_stat_reg #(.IDX_W(IDX_W)) u_sts (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .clr_mask      (clr_mask),
        .ev_buf_done   (ev_buf_done),
        .ev_ioc        (ev_ioc),
        .ev_last_valid (ev_last_valid),
        .ev_fifo_err   (ev_fifo_err),
        .sts_byte      (sts_byte),
        .idx           (idx)
    );

    // Purpose: align the enables with their status bits and assemble the dword
    always_comb begin
        en_mask           = 8'h00;
        en_mask[STS_LVB]  = en_lvb;
        en_mask[STS_DONE] = en_done;
        en_mask[STS_FERR] = en_ferr;
        idx_byte          = 8'(idx);
        reg_dw            = 32'h0;
        reg_dw[8*LANE_STS +: 8] = sts_byte;
        reg_dw[8*LANE_IDX +: 8] = idx_byte;
        reg_dw[8*LANE_CTL +: 8] = ctl_byte;
    end

    dmac_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_byte (sts_byte),
        .en_mask  (en_mask),
        .irq      (irq)
    );

    // Purpose: register the read response and the one-cycle error/reset strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= 32'h0;
            acc_err   <= 1'b0;
            proto_err <= 1'b0;
            dma_rst   <= 1'b0;
        end else begin
            rd_valid  <= req_valid && !req_write;
            rd_data   <= (req_valid && !req_write && hit && !bad)
                         ? ((reg_dw >> {lane_sel, 3'b000}) & rd_mask) : 32'h0;
            acc_err   <= bad;
            proto_err <= proto_hit;
            dma_rst   <= soft_rst;
        end
    end

    assign dma_run = run;

endmodule

// File: rtl/dmac_chk.sv
// Module: protocol checker for dmac_chan, attached with bind below.
// Assumes: rst_n is the synchronous active-low reset of the block.
module dmac_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        acc_err,
    input logic        proto_err,
    input logic        dma_rst,
    input logic        dma_run,
    input logic        irq,
    input logic        ev_fifo_err,
    input logic        soft_rst,
    input logic [7:0]  sts_byte,
    input logic [7:0]  idx_byte,
    input logic [7:0]  en_mask
);

    AST_RST_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n) dma_rst |-> !dma_run); // R3
    AST_RST_CLEARS_IDX: assert property (@(posedge clk) disable iff (!rst_n) dma_rst |-> (idx_byte == 8'h00)); // R3
    AST_PROTO_NO_RST: assert property (@(posedge clk) disable iff (!rst_n) proto_err |-> !dma_rst); // R4
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ev_fifo_err && !soft_rst) |=> sts_byte[4]); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ((sts_byte & en_mask) == 8'h00) |=> !irq); // R8
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n) acc_err |-> (rd_data == 32'h0)); // R10
    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $past(req_valid)); // R11

endmodule

bind dmac_chan dmac_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .acc_err     (acc_err),
    .proto_err   (proto_err),
    .dma_rst     (dma_rst),
    .dma_run     (dma_run),
    .irq         (irq),
    .ev_fifo_err (ev_fifo_err),
    .soft_rst    (soft_rst),
    .sts_byte    (sts_byte),
    .idx_byte    (idx_byte),
    .en_mask     (en_mask)
);

// File: tb/sim_dmac_chan.sv
`timescale 1ns/100ps
// Bench: behavioural reference model stepped on each rising edge and
// compared with every output on the falling edge, plus directed reads.
module sim_dmac_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [7:0]  req_addr = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic        ev_buf_done = 1'b0, ev_ioc = 1'b0, ev_last_valid = 1'b0, ev_fifo_err = 1'b0;
    logic        rd_valid, acc_err, proto_err, irq, dma_run, dma_rst;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;

    dmac_chan u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err), .proto_err(proto_err),
        .ev_buf_done(ev_buf_done), .ev_ioc(ev_ioc), .ev_last_valid(ev_last_valid),
        .ev_fifo_err(ev_fifo_err), .irq(irq), .dma_run(dma_run), .dma_rst(dma_rst)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    bit       m_run, m_en_done, m_en_ferr, m_en_lvb;
    bit [7:0] m_sts, m_idx;
    bit       m_irq, m_rv, m_ae, m_pe, m_dr;
    bit [31:0] m_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_en_done = 0; m_en_ferr = 0; m_en_lvb = 0;
            m_sts = 0; m_idx = 0; m_irq = 0; m_rv = 0; m_ae = 0; m_pe = 0; m_dr = 0; m_rd = 0;
        end else begin
            int nb, off;
            bit ok, inwin, srst;
            bit [7:0] bytes[4];
            bit [7:0] clr, cb;
            bit wctl;
            m_irq = (m_sts[4] && m_en_ferr) || (m_sts[3] && m_en_done) || (m_sts[2] && m_en_lvb);
            nb = (req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : (req_size == 2'd2) ? 4 : 0;
            off = int'(req_addr[1:0]);
            ok = (nb != 0) && (off + nb <= 4);
            inwin = (req_addr[7:2] == 6'h02);
            bytes[0] = m_sts; bytes[1] = 8'h00; bytes[2] = m_idx;
            bytes[3] = {3'b000, m_en_done, m_en_ferr, m_en_lvb, 1'b0, m_run};
            m_rv = req_valid && !req_write;
            m_ae = req_valid && !ok;
            m_rd = 0; clr = 0; cb = 0; wctl = 0; srst = 0; m_pe = 0;
            if (m_rv && ok && inwin)
                for (int b = 0; b < nb; b++) m_rd[8*b +: 8] = bytes[off+b];
            if (req_valid && req_write && ok && inwin)
                for (int b = 0; b < nb; b++) begin
                    if (off + b == 0) clr = req_wdata[8*b +: 8];
                    if (off + b == 3) begin wctl = 1; cb = req_wdata[8*b +: 8]; end
                end
            if (wctl) begin
                m_en_done = cb[4]; m_en_ferr = cb[3]; m_en_lvb = cb[2];
                if (cb[1] && m_run) m_pe = 1;
                if (cb[1] && !m_run) begin srst = 1; m_run = 0; end
                else m_run = cb[0];
            end
            if (srst) begin
                m_sts = 0; m_idx = 0;
            end else begin
                m_sts = m_sts & ~(clr & 8'h1C);
                if (ev_last_valid) m_sts[2] = 1;
                if (ev_buf_done && ev_ioc) m_sts[3] = 1;
                if (ev_fifo_err) m_sts[4] = 1;
                if (ev_buf_done) m_idx = m_idx + 8'd1;
            end
            m_dr = srst;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R2 dma_run", {31'b0, dma_run}, {31'b0, m_run});
            chk("R3 dma_rst", {31'b0, dma_rst}, {31'b0, m_dr});
            chk("R4 proto_err", {31'b0, proto_err}, {31'b0, m_pe});
            chk("R10 acc_err", {31'b0, acc_err}, {31'b0, m_ae});
            chk("R11 rd_valid", {31'b0, rd_valid}, {31'b0, m_rv});
            chk("R9 rd_data", rd_data, m_rd);
        end
    end

    // One access; called at a falling edge, returns at the next one
    task automatic acc(input bit w, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
        req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] exp, input string tag);
        acc(0, sz, a, 32'h0);
        chk(tag, rd_data, exp);
        chk("R11 read strobe", {31'b0, rd_valid}, 32'h1);
    endtask

    task automatic ev(input bit done, input bit ioc, input bit lvb, input bit ferr);
        ev_buf_done = done; ev_ioc = ioc; ev_last_valid = lvb; ev_fifo_err = ferr;
        @(negedge clk);
        ev_buf_done = 0; ev_ioc = 0; ev_last_valid = 0; ev_fifo_err = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R11 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; cmp_on = 1;
        // R1: reset state
        rd(2'd2, 8'h08, 32'h0, "R1 dword after reset");
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        chk("R1 run low", {31'b0, dma_run}, 32'h0);
        // R2: enables + run
        acc(1, 2'd0, 8'h0B, 32'h1D);
        chk("R2 run level", {31'b0, dma_run}, 32'h1);
        rd(2'd0, 8'h0B, 32'h1D, "R2 control readback");
        // R4: reset command while running
        acc(1, 2'd0, 8'h0B, 32'hFF);
        chk("R4 proto_err", {31'b0, proto_err}, 32'h1);
        chk("R4 no reset pulse", {31'b0, dma_rst}, 32'h0);
        rd(2'd0, 8'h0B, 32'h1D, "R2 reserved bits zero");
        // R6/R8: FIFO error, irq one cycle after the flag
        ev(0, 0, 0, 1);
        chk("R8 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq raised", {31'b0, irq}, 32'h1);
        rd(2'd0, 8'h08, 32'h10, "R6 fifo flag");
        // R5: completion without and with IOC
        ev(1, 0, 0, 0);
        rd(2'd1, 8'h0A, 32'h1D01, "R5 counter one");
        rd(2'd0, 8'h08, 32'h10, "R5 no done flag without ioc");
        ev(1, 1, 0, 0);
        rd(2'd0, 8'h08, 32'h18, "R5 done flag with ioc");
        // R7: write-1-to-clear, then set wins over clear
        acc(1, 2'd0, 8'h08, 32'h10);
        rd(2'd0, 8'h08, 32'h08, "R7 cleared fifo flag");
        ev_last_valid = 1;
        acc(1, 2'd0, 8'h08, 32'h0C);
        ev_last_valid = 0;
        rd(2'd0, 8'h08, 32'h04, "R7 set wins over clear");
        // R6: masked events set status without irq
        acc(1, 2'd0, 8'h0B, 32'h01);
        @(negedge clk);
        ev(0, 0, 0, 1);
        @(negedge clk);
        chk("R6 masked irq stays low", {31'b0, irq}, 32'h0);
        rd(2'd0, 8'h08, 32'h14, "R6 masked flag set");
        // R12: pause keeps state
        acc(1, 2'd0, 8'h0B, 32'h00);
        chk("R12 paused", {31'b0, dma_run}, 32'h0);
        rd(2'd2, 8'h08, 32'h0002_0014, "R12 state kept after pause");
        // R3: reset command while paused
        acc(1, 2'd0, 8'h0B, 32'h1E);
        chk("R3 reset pulse", {31'b0, dma_rst}, 32'h1);
        @(negedge clk);
        chk("R3 pulse one cycle", {31'b0, dma_rst}, 32'h0);
        rd(2'd2, 8'h08, 32'h1C00_0000, "R3 enables survive, rest cleared");
        // R10: boundary crossing and bad size
        rd(2'd2, 8'h09, 32'h0, "R10 crossing read zero");
        chk("R10 acc_err", {31'b0, acc_err}, 32'h1);
        acc(1, 2'd1, 8'h0B, 32'h0001);
        chk("R10 crossing write flagged", {31'b0, acc_err}, 32'h1);
        rd(2'd0, 8'h0B, 32'h1C, "R10 crossing write ignored");
        rd(2'd3, 8'h08, 32'h0, "R10 bad size");
        // R9: lane mapping
        ev(1, 0, 0, 0);
        rd(2'd1, 8'h09, 32'h0100, "R9 word at 09h");
        rd(2'd0, 8'h0A, 32'h01, "R9 byte counter");
        rd(2'd2, 8'h10, 32'h0, "R9 other dword");
        // R8: enables active after the reset command
        ev(0, 0, 0, 1);
        @(negedge clk);
        chk("R8 irq after reset command", {31'b0, irq}, 32'h1);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule